// File: doc/BRIEF.md
# Decoupled Register Write-Back Scoreboard

A long-running custom instruction can leave the pipeline at its spawn stage and deliver its destination value later, while the core keeps executing. This unit tracks which architectural registers are still waiting on such a result. When the instruction passes the spawn stage, the unit marks its 5-bit destination busy unless the instruction is flushed there. Any instruction in the issue stage that names a busy register as a source or as its destination is held by a stall until the result has arrived.

When the custom logic finishes, it pulses a commit with a destination address and a 32-bit value. The unit queues the commit and places it on the register file's single write port in a cycle when the normal pipeline is not writing back. In that same cycle it raises an acceptance response and a committed-done flag with the committed address. Consumers that handle hazards on their own can use the flag and address. The busy bit for that register drops one cycle later. Results can therefore retire in an order different from their spawn order.

Top module: `dwb_scoreboard`

## Requirements
- R1: A spawn (`spawn_valid_i`=1, `spawn_flush_i`=0) with a nonzero `spawn_rd_i` marks that register busy from the next cycle on.
- R2: A spawn with `spawn_flush_i`=1 in the same cycle leaves the busy state of its destination unchanged.
- R3: Register 0 is never busy. A commit addressed to register 0 is discarded: it causes no register-file write, no response and no done flag.
- R4: While `iss_valid_i`=1, `iss_stall_o` is 1 exactly when at least one of `iss_rs1_i`, `iss_rs2_i` or `iss_rd_i` is busy. While `iss_valid_i`=0 it is 0.
- R5: Commits are queued in arrival order, up to `QDEPTH` outstanding. A commit reaches the write port no earlier than the cycle after its pulse.
- R6: When `pipe_wr_en_i`=1, the write port carries the pipeline address and data, and no commit is granted that cycle. The waiting commit goes out in the next cycle without a pipeline write.
- R7: In the cycle a commit drives the write port (`rf_we_o`=1, its address and data), `cmt_resp_o` and `cmt_done_o` are 1 and `cmt_done_addr_o` equals the committed address. In all other cycles these are 0.
- R8: The busy bit of a committed register is clear from the cycle after its commit drives the write port.
- R9: Reset (`rst_ni`=0) clears every busy bit and empties the commit queue.
- R10: With no pipeline write and no queued commit, `rf_we_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spawn_valid_i | input | 1 | Decoupled instruction passes the spawn stage |
| spawn_flush_i | input | 1 | Spawn-stage instruction is flushed |
| spawn_rd_i | input | 5 | Destination field of the spawning instruction |
| iss_valid_i | input | 1 | Issue stage holds an instruction |
| iss_rs1_i | input | 5 | First source register in issue |
| iss_rs2_i | input | 5 | Second source register in issue |
| iss_rd_i | input | 5 | Destination register in issue |
| iss_stall_o | output | 1 | Hold the issue stage |
| pipe_wr_en_i | input | 1 | Normal pipeline write-back request |
| pipe_wr_addr_i | input | 5 | Pipeline write-back address |
| pipe_wr_data_i | input | 32 | Pipeline write-back data |
| cmt_valid_i | input | 1 | One-cycle commit pulse from the custom logic |
| cmt_addr_i | input | 5 | Commit destination |
| cmt_data_i | input | 32 | Commit value |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 5 | Register-file write address |
| rf_wdata_o | output | 32 | Register-file write data |
| cmt_resp_o | output | 1 | Commit accepted into the register file |
| cmt_done_o | output | 1 | A decoupled result was committed |
| cmt_done_addr_o | output | 5 | Register of that committed result |

## Verification
The hardest case to reach is several decoupled results waiting in the queue while the pipeline occupies the write port. The order of retirement must then differ from the order of spawning, and a busy bit must be released only after its own commit has gone out. The bench spawns three destinations, commits them in a shuffled order, and holds pipeline writes across two consecutive cycles so that the queue backs up. It then checks the done address in each following cycle, and the stall on each register just before and just after its release. A second sequence fills all 31 busy bits and then resets the unit in the middle of operation.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
  localparam int unsigned REG_AW = 5;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned NREG   = 1 << REG_AW;

  typedef struct packed {
    logic [REG_AW-1:0] addr;
    logic [XLEN-1:0]   data;
  } commit_t;
endpackage

// File: rtl/dwb_busy_table.sv
module dwb_busy_table
  import dwb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_en_i,
  input  logic [REG_AW-1:0] set_addr_i,
  input  logic              clr_en_i,
  input  logic [REG_AW-1:0] clr_addr_i,
  input  logic              chk_en_i,
  input  logic [REG_AW-1:0] chk_a_i,
  input  logic [REG_AW-1:0] chk_b_i,
  input  logic [REG_AW-1:0] chk_c_i,
  output logic              hit_o
);
  logic [NREG-1:0] busy_q;

  for (genvar g = 0; g < NREG; g++) begin : g_bit
    if (g == 0) begin : g_zero
      assign busy_q[g] = 1'b0;
    end else begin : g_reg
      logic b_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                         b_q <= 1'b0;
        else if (set_en_i && set_addr_i == REG_AW'(g))       b_q <= 1'b1;
        else if (clr_en_i && clr_addr_i == REG_AW'(g))       b_q <= 1'b0;
      end
      assign busy_q[g] = b_q;
    end
  end

  assign hit_o = chk_en_i & (busy_q[chk_a_i] | busy_q[chk_b_i] | busy_q[chk_c_i]);

  p_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> busy_q[$past(set_addr_i)]);

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !(set_en_i && set_addr_i == clr_addr_i)) |=> !busy_q[$past(clr_addr_i)]);
endmodule

// File: rtl/dwb_commit_queue.sv
module dwb_commit_queue
  import dwb_pkg::*;
#(
  parameter int unsigned QDEPTH = 8
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    push_i,
  input  commit_t push_data_i,
  input  logic    pop_i,
  output logic    valid_o,
  output commit_t head_o
);
  localparam int unsigned PW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  commit_t         mem_q [QDEPTH];
  logic [PW-1:0]   wr_q, rd_q;
  logic [PW:0]     cnt_q;
  logic            full;
  logic            do_pop;

  assign full    = (cnt_q == (PW+1)'(QDEPTH));
  assign valid_o = (cnt_q != '0);
  assign do_pop  = pop_i & valid_o;
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i && !full) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i && !full) wr_q <= (wr_q == PW'(QDEPTH-1)) ? '0 : wr_q + 1'b1;
      if (do_pop)          rd_q <= (rd_q == PW'(QDEPTH-1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + (PW+1)'(push_i && !full) - (PW+1)'(do_pop);
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full);

  p_fill_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !do_pop) |=> valid_o);
endmodule

// File: rtl/dwb_wb_arbiter.sv
module dwb_wb_arbiter
  import dwb_pkg::*;
(
  input  logic              pipe_en_i,
  input  logic [REG_AW-1:0] pipe_addr_i,
  input  logic [XLEN-1:0]   pipe_data_i,
  input  logic              head_valid_i,
  input  commit_t           head_i,
  output logic              we_o,
  output logic [REG_AW-1:0] waddr_o,
  output logic [XLEN-1:0]   wdata_o,
  output logic              grant_o
);
  always_comb begin
    grant_o = head_valid_i & ~pipe_en_i;
    we_o    = pipe_en_i | head_valid_i;
    if (pipe_en_i) begin
      waddr_o = pipe_addr_i;
      wdata_o = pipe_data_i;
    end else if (head_valid_i) begin
      waddr_o = head_i.addr;
      wdata_o = head_i.data;
    end else begin
      waddr_o = '0;
      wdata_o = '0;
    end
  end

  always_comb begin
    p_exclusive_r6: assert (!(grant_o && pipe_en_i));
  end
endmodule

// File: rtl/dwb_scoreboard.sv
module dwb_scoreboard
  import dwb_pkg::*;
#(
  parameter int unsigned QDEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spawn_valid_i,
  input  logic              spawn_flush_i,
  input  logic [REG_AW-1:0] spawn_rd_i,
  input  logic              iss_valid_i,
  input  logic [REG_AW-1:0] iss_rs1_i,
  input  logic [REG_AW-1:0] iss_rs2_i,
  input  logic [REG_AW-1:0] iss_rd_i,
  output logic              iss_stall_o,
  input  logic              pipe_wr_en_i,
  input  logic [REG_AW-1:0] pipe_wr_addr_i,
  input  logic [XLEN-1:0]   pipe_wr_data_i,
  input  logic              cmt_valid_i,
  input  logic [REG_AW-1:0] cmt_addr_i,
  input  logic [XLEN-1:0]   cmt_data_i,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              cmt_resp_o,
  output logic              cmt_done_o,
  output logic [REG_AW-1:0] cmt_done_addr_o
);
  logic    set_en;
  logic    push;
  logic    grant;
  logic    head_valid;
  commit_t head;
  commit_t push_data;

  // flushed spawns and x0 never reserve a register
  assign set_en    = spawn_valid_i & ~spawn_flush_i & (spawn_rd_i != '0);
  assign push      = cmt_valid_i & (cmt_addr_i != '0);
  assign push_data = '{addr: cmt_addr_i, data: cmt_data_i};

  dwb_busy_table u_busy (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_en_i   (set_en),
    .set_addr_i (spawn_rd_i),
    .clr_en_i   (grant),
    .clr_addr_i (head.addr),
    .chk_en_i   (iss_valid_i),
    .chk_a_i    (iss_rs1_i),
    .chk_b_i    (iss_rs2_i),
    .chk_c_i    (iss_rd_i),
    .hit_o      (iss_stall_o)
  );

  dwb_commit_queue #(.QDEPTH(QDEPTH)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (grant),
    .valid_o     (head_valid),
    .head_o      (head)
  );

  dwb_wb_arbiter u_arb (
    .pipe_en_i    (pipe_wr_en_i),
    .pipe_addr_i  (pipe_wr_addr_i),
    .pipe_data_i  (pipe_wr_data_i),
    .head_valid_i (head_valid),
    .head_i       (head),
    .we_o         (rf_we_o),
    .waddr_o      (rf_waddr_o),
    .wdata_o      (rf_wdata_o),
    .grant_o      (grant)
  );

  assign cmt_resp_o      = grant;
  assign cmt_done_o      = grant;
  assign cmt_done_addr_o = grant ? head.addr : '0;

  p_pipe_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_wr_en_i |-> (rf_we_o && rf_waddr_o == pipe_wr_addr_i && !cmt_resp_o));

  p_no_x0_commit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o && !pipe_wr_en_i) |-> rf_waddr_o != '0);

  p_resp_with_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmt_resp_o |-> (rf_we_o && cmt_done_o && rf_waddr_o == cmt_done_addr_o));

  p_idle_port_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pipe_wr_en_i && !cmt_resp_o) |-> !rf_we_o);

  p_no_stall_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iss_valid_i |-> !iss_stall_o);
endmodule

// File: tb/dwb_scoreboard_bench.sv
module dwb_scoreboard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spawn_valid, spawn_flush, iss_valid, pipe_en, cmt_valid;
  logic [4:0]  spawn_rd, rs1, rs2, rd, pipe_addr, cmt_addr;
  logic [31:0] pipe_data, cmt_data;
  logic        stall, we, resp, done;
  logic [4:0]  waddr, done_addr;
  logic [31:0] wdata;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  dwb_scoreboard u_dwb_scoreboard (
    .clk_i(clk), .rst_ni(rst_n),
    .spawn_valid_i(spawn_valid), .spawn_flush_i(spawn_flush), .spawn_rd_i(spawn_rd),
    .iss_valid_i(iss_valid), .iss_rs1_i(rs1), .iss_rs2_i(rs2), .iss_rd_i(rd),
    .iss_stall_o(stall),
    .pipe_wr_en_i(pipe_en), .pipe_wr_addr_i(pipe_addr), .pipe_wr_data_i(pipe_data),
    .cmt_valid_i(cmt_valid), .cmt_addr_i(cmt_addr), .cmt_data_i(cmt_data),
    .rf_we_o(we), .rf_waddr_o(waddr), .rf_wdata_o(wdata),
    .cmt_resp_o(resp), .cmt_done_o(done), .cmt_done_addr_o(done_addr)
  );

  // source: 0 none, 1 pipeline, 2 commit
  typedef struct packed {
    logic sv; logic [4:0] srd; logic sfl;
    logic iv; logic [4:0] r1; logic [4:0] r2; logic [4:0] rdd;
    logic pe; logic [4:0] pa;
    logic cv; logic [4:0] ca;
    logic e_stall; logic [1:0] e_src; logic [4:0] e_addr;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1,5'd5,1'b0, 1'b1,5'd5,5'd0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,2'd0,5'd0},
    '{1'b1,5'd0,1'b0, 1'b1,5'd5,5'd0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b1,2'd0,5'd0},
    '{1'b1,5'd7,1'b1, 1'b1,5'd0,5'd0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,2'd0,5'd0},
    '{1'b1,5'd9,1'b0, 1'b1,5'd0,5'd7,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,2'd0,5'd0},
    '{1'b0,5'd0,1'b0, 1'b1,5'd0,5'd0,5'd9, 1'b0,5'd0, 1'b1,5'd9, 1'b1,2'd0,5'd0},
    '{1'b0,5'd0,1'b0, 1'b1,5'd0,5'd0,5'd9, 1'b0,5'd0, 1'b1,5'd5, 1'b1,2'd2,5'd9},
    '{1'b0,5'd0,1'b0, 1'b1,5'd5,5'd0,5'd9, 1'b1,5'd3, 1'b0,5'd0, 1'b1,2'd1,5'd3},
    '{1'b0,5'd0,1'b0, 1'b1,5'd5,5'd0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b1,2'd2,5'd5},
    '{1'b0,5'd0,1'b0, 1'b1,5'd5,5'd0,5'd0, 1'b0,5'd0, 1'b1,5'd0, 1'b0,2'd0,5'd0},
    '{1'b0,5'd0,1'b0, 1'b1,5'd0,5'd0,5'd0, 1'b0,5'd0, 1'b0,5'd0, 1'b0,2'd0,5'd0}
  };

  function automatic logic [31:0] pdat(input logic [4:0] a); return 32'hA5A5_0000 | 32'(a); endfunction
  function automatic logic [31:0] cdat(input logic [4:0] a); return 32'hC0DE_0000 | 32'(a); endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h @%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic idle();
    spawn_valid = 0; spawn_flush = 0; spawn_rd = 0;
    iss_valid = 0; rs1 = 0; rs2 = 0; rd = 0;
    pipe_en = 0; pipe_addr = 0; pipe_data = 0;
    cmt_valid = 0; cmt_addr = 0; cmt_data = 0;
  endtask

  task automatic issue(input logic [4:0] a);
    iss_valid = 1; rs1 = a; rs2 = 0; rd = 0;
  endtask

  task automatic commit(input logic [4:0] a);
    cmt_valid = 1; cmt_addr = a; cmt_data = cdat(a);
  endtask

  task automatic pipe(input logic [4:0] a);
    pipe_en = 1; pipe_addr = a; pipe_data = pdat(a);
  endtask

  task automatic cyc();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    cyc(); issue(5); rs2 = 9; rd = 31; #2;
    chk("R9", "stall after reset", 32'(stall), 0);
    chk("R10", "we idle", 32'(we), 0);
    chk("R7", "resp idle", 32'(resp), 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      cyc();
      spawn_valid = v.sv; spawn_rd = v.srd; spawn_flush = v.sfl;
      iss_valid = v.iv; rs1 = v.r1; rs2 = v.r2; rd = v.rdd;
      pipe_en = v.pe; pipe_addr = v.pa; pipe_data = pdat(v.pa);
      cmt_valid = v.cv; cmt_addr = v.ca; cmt_data = cdat(v.ca);
      #2;
      // rows: R1 spawn, R2 flush, R3 x0, R4 stall, R5/R6 queue+priority, R7 done, R8 clear
      chk("R4", $sformatf("row%0d stall", i), 32'(stall), 32'(v.e_stall));
      chk("R6", $sformatf("row%0d we", i), 32'(we), 32'(v.e_src != 0));
      if (v.e_src != 0) begin
        chk("R6", $sformatf("row%0d waddr", i), 32'(waddr), 32'(v.e_addr));
        chk("R7", $sformatf("row%0d wdata", i), wdata, (v.e_src == 1) ? pdat(v.e_addr) : cdat(v.e_addr));
      end
      chk("R7", $sformatf("row%0d resp", i), 32'(resp), 32'(v.e_src == 2));
      chk("R7", $sformatf("row%0d done", i), 32'(done), 32'(v.e_src == 2));
      if (v.e_src == 2) chk("R7", $sformatf("row%0d done_addr", i), 32'(done_addr), 32'(v.e_addr));
    end
    // R3: the x0 commit of row 8 must not appear one cycle later (row 9 checked), and
    // R8: register 5 free after its row-7 commit (row 8 checked)

    // out-of-order retirement with backlog
    cyc(); spawn_valid = 1; spawn_rd = 10;
    cyc(); spawn_valid = 1; spawn_rd = 11;
    cyc(); spawn_valid = 1; spawn_rd = 12;
    cyc(); commit(12); issue(12); #2;
    chk("R1", "r12 busy", 32'(stall), 1);
    cyc(); commit(10); pipe(1); #2;
    chk("R6", "pipe holds port", 32'(waddr), 1);
    chk("R6", "no resp under pipe", 32'(resp), 0);
    cyc(); commit(11); pipe(2); #2;
    chk("R6", "second pipe", 32'(waddr), 2);
    chk("R7", "no done under pipe", 32'(done), 0);
    cyc(); issue(12); #2;
    chk("R5", "first out r12", 32'(done_addr), 12);
    chk("R7", "data r12", wdata, cdat(12));
    chk("R8", "r12 busy while writing", 32'(stall), 1);
    cyc(); issue(12); #2;
    chk("R5", "second out r10", 32'(done_addr), 10);
    chk("R8", "r12 released", 32'(stall), 0);
    cyc(); issue(10); #2;
    chk("R5", "third out r11", 32'(done_addr), 11);
    chk("R8", "r10 released", 32'(stall), 0);
    cyc(); issue(11); #2;
    chk("R10", "queue drained", 32'(we), 0);
    chk("R8", "r11 released", 32'(stall), 0);

    // fill every register, then reset in the middle
    for (int r = 1; r < 32; r++) begin
      cyc(); spawn_valid = 1; spawn_rd = 5'(r);
    end
    cyc(); iss_valid = 1; rs1 = 0; rs2 = 0; rd = 0; #2;
    chk("R3", "x0 never busy", 32'(stall), 0);
    begin
      int hits = 0;
      for (int r = 1; r < 32; r++) begin
        issue(5'(r)); #1;
        if (stall) hits++;
      end
      chk("R1", "all 31 busy", 32'(hits), 31);
    end
    iss_valid = 0; #1;
    chk("R4", "no stall without valid", 32'(stall), 0);
    cyc(); commit(4);
    cyc(); rst_n = 1'b0;
    cyc(); rst_n = 1'b1;
    cyc(); #2;
    chk("R9", "queue emptied", 32'(we), 0);
    begin
      int hits = 0;
      for (int r = 1; r < 32; r++) begin
        issue(5'(r)); #1;
        if (stall) hits++;
      end
      chk("R9", "busy cleared", 32'(hits), 0);
    end

    // R4 on rs2 and rd, R2 on an already-idle register
    cyc(); spawn_valid = 1; spawn_rd = 20;
    cyc(); spawn_valid = 1; spawn_rd = 21; spawn_flush = 1;
    cyc(); iss_valid = 1; rs1 = 3; rs2 = 20; rd = 4; #2;
    chk("R4", "rs2 busy", 32'(stall), 1);
    rs2 = 4; rd = 20; #1;
    chk("R4", "rd busy", 32'(stall), 1);
    rd = 21; #1;
    chk("R2", "flushed r21 idle", 32'(stall), 0);

    cyc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule